// File: doc/BRIEF.md
# In-Place Memory Sorting Engine

This block sorts a small set of unsigned words in ascending order. The words sit in an internal memory of K = 2^AW entries. A state machine drives a datapath that holds two index counters, two operand registers, a magnitude comparator, and multiplexers for the memory address and write data.

While `run` is low the engine is in load mode. External logic writes words through `addr`, `wr_data` and `wr_en`. When `run` goes high, an exchange sort runs over the memory without a copy. The outer index i steps from 0 to K-2 and the inner index j steps from i+1 to K-1. Operand A holds the current minimum candidate for slot i. Operand B holds slot j. When A > B, the two slots are swapped and A is reloaded from slot i.

`done` rises when the sort is finished and stays high until `run` drops. The sorted words can be read back through `addr` and `rd_en`. This is possible in the finished state and in load mode.

The states are:
- IDLE: load and read allowed, i cleared.
- FETCH_A: A from slot i, j set to i+1.
- FETCH_B: B from slot j.
- CMP: compare.
- WR_I: B written to slot i.
- WR_J: A written to slot j.
- RELOAD: A from slot i.
- NEXT: advance the indices.
- DONE: `done` high, read allowed.

The transitions are:
- IDLE→FETCH_A when `run` is high.
- FETCH_A→FETCH_B.
- FETCH_B→CMP.
- CMP→WR_I when A > B, otherwise CMP→NEXT.
- WR_I→WR_J→RELOAD→NEXT.
- NEXT→FETCH_B when j < K-1.
- NEXT→FETCH_A when j = K-1 and i < K-2, with i incremented.
- NEXT→DONE when j = K-1 and i = K-2.
- DONE→IDLE when `run` is low.

Top module: `sort_engine`

## Requirements
- R1: An active-low asynchronous `rst_n` returns the controller to IDLE, so `done` is 0. It clears the indices and operands but leaves the memory contents unchanged.
- R2: In IDLE, a high `wr_en` at a rising clock edge writes `wr_data` into slot `addr`.
- R3: In IDLE or DONE, with `rd_en` high, `rd_data` shows slot `addr` combinationally. With `rd_en` low, or while a sort runs, `rd_data` is 0.
- R4: After `done`, slots 0..K-1 hold the loaded words in non-decreasing unsigned order, as a permutation of the input.
- R5: The comparison is strict and unsigned. Equal words are never swapped, and 8'h80 and above rank above 8'h7F.
- R6: Take `run` first sampled high at a rising edge. `done` becomes 1 after exactly 1 + (K-1) + 3·K(K-1)/2 + 3·S edges, where S is the number of swaps the exchange sort performs. Each swap costs a write to slot i, a write to slot j and an A reload.
- R7: `done` stays 1 while `run` is high. One edge after `run` is seen low, it clears and the engine accepts loads again.
- R8: `wr_en` pulses while a sort runs have no effect on the memory.
- R9: The outer index never exceeds K-2, and when B is fetched the inner index is above the outer index.
- R10: On entering NEXT, A is not greater than B, so A holds the minimum seen so far for slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 0 = load/read mode, 1 = start and hold sort |
| wr_en | input | 1 | Write strobe for load mode |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | External slot address |
| wr_data | input | W | Word to load |
| rd_data | output | W | Word read from slot `addr`, or 0 |
| done | output | 1 | Sort finished, held until `run` drops |

## Verification
The bench sweeps all 256 arrangements of four words drawn from {00, 01, 80, FF}. This sweep covers runs of duplicates, reversed inputs and values on both sides of the sign bit. A design that swapped equal words, or compared as signed, would reorder data or take extra cycles. The exact completion latency is checked against a swap count the bench derives for each pattern. This catches a skipped reload, a missing write cycle or an off-by-one loop bound. Write strobes during a sort, reads while busy, the hold and release of `done`, and a reset between load and readback are also exercised. These expose an engine that corrupts memory, leaks data or clears its storage on reset.

// File: rtl/sort_pkg.sv
package sort_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_A,
        S_FETCH_B,
        S_CMP,
        S_WR_I,
        S_WR_J,
        S_RELOAD,
        S_NEXT,
        S_DONE
    } sort_state_t;

    typedef struct packed {
        logic ld_i;        // clear outer index
        logic inc_i;       // step outer index
        logic ld_j;        // inner index <= outer + 1
        logic inc_j;       // step inner index
        logic en_a;        // capture operand A
        logic en_b;        // capture operand B
        logic addr_sel_j;  // memory address from j (else i)
        logic wdat_sel_a;  // write data from A (else B)
        logic sort_we;     // internal memory write
        logic ext_sel;     // external port owns the memory
        logic load_ok;     // external writes permitted
    } sort_ctl_t;

endpackage

// File: rtl/sort_store.sv
module sort_store #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sort_path.sv
module sort_path
    import sort_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sort_ctl_t     ctl,
    input  logic [AW-1:0] ext_addr,
    input  logic [W-1:0]  ext_data,
    input  logic          ext_we,
    input  logic [W-1:0]  mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_we,
    output logic          a_gt_b,
    output logic          zi,
    output logic          zj
);
    localparam int K = 1 << AW;
    localparam logic [AW-1:0] I_LAST = AW'(K - 2);
    localparam logic [AW-1:0] J_LAST = AW'(K - 1);

    logic [AW-1:0] i_q, j_q;
    logic [W-1:0]  a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
            j_q <= '0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ctl.ld_i) begin
                i_q <= '0;
            end else if (ctl.inc_i) begin
                i_q <= i_q + 1'b1;
            end
            if (ctl.ld_j) begin
                j_q <= i_q + 1'b1;
            end else if (ctl.inc_j) begin
                j_q <= j_q + 1'b1;
            end
            if (ctl.en_a) begin
                a_q <= mem_rdata;
            end
            if (ctl.en_b) begin
                b_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        if (ctl.ext_sel) begin
            mem_addr  = ext_addr;
            mem_wdata = ext_data;
        end else begin
            mem_addr  = ctl.addr_sel_j ? j_q : i_q;
            mem_wdata = ctl.wdat_sel_a ? a_q : b_q;
        end
    end

    assign mem_we = ctl.sort_we | (ctl.load_ok & ext_we);
    assign a_gt_b = a_q > b_q;
    assign zi     = (i_q == I_LAST);
    assign zj     = (j_q == J_LAST);

    // R9: outer index stays inside its range
    a_r9_i_bound : assert property (@(posedge clk) disable iff (!rst_n)
        i_q <= I_LAST);

    // R9: inner index is above outer index whenever B is fetched
    a_r9_j_above_i : assert property (@(posedge clk) disable iff (!rst_n)
        ctl.en_b |-> (j_q > i_q));

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sort_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        a_gt_b,
    input  logic        zi,
    input  logic        zj,
    output sort_state_t state,
    output sort_ctl_t   ctl,
    output logic        done
);
    sort_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt  = state;
        ctl  = '0;
        done = 1'b0;
        unique case (state)
            S_IDLE: begin
                ctl.ld_i    = 1'b1;
                ctl.ext_sel = 1'b1;
                ctl.load_ok = 1'b1;
                if (run) nxt = S_FETCH_A;
            end
            S_FETCH_A: begin
                ctl.en_a = 1'b1;
                ctl.ld_j = 1'b1;
                nxt      = S_FETCH_B;
            end
            S_FETCH_B: begin
                ctl.addr_sel_j = 1'b1;
                ctl.en_b       = 1'b1;
                nxt            = S_CMP;
            end
            S_CMP: begin
                nxt = a_gt_b ? S_WR_I : S_NEXT;
            end
            S_WR_I: begin
                ctl.sort_we = 1'b1;
                nxt         = S_WR_J;
            end
            S_WR_J: begin
                ctl.sort_we    = 1'b1;
                ctl.addr_sel_j = 1'b1;
                ctl.wdat_sel_a = 1'b1;
                nxt            = S_RELOAD;
            end
            S_RELOAD: begin
                ctl.en_a = 1'b1;
                nxt      = S_NEXT;
            end
            S_NEXT: begin
                if (!zj) begin
                    ctl.inc_j = 1'b1;
                    nxt       = S_FETCH_B;
                end else if (!zi) begin
                    ctl.inc_i = 1'b1;
                    nxt       = S_FETCH_A;
                end else begin
                    nxt = S_DONE;
                end
            end
            S_DONE: begin
                done        = 1'b1;
                ctl.ext_sel = 1'b1;
                if (!run) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // R7: finished state holds while run stays high
    a_r7_done_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && run) |=> (state == S_DONE));

    // R7: dropping run returns the engine to load mode
    a_r7_done_release : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !run) |=> (state == S_IDLE));

    // R10: a comparison is reached only from fetching B
    a_r10_cmp_after_fetch : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMP) |-> ($past(state) == S_FETCH_B));

endmodule

// File: rtl/sort_engine.sv
module sort_engine
    import sort_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          done
);
    sort_state_t   state;
    sort_ctl_t     ctl;
    logic          a_gt_b, zi, zj;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata, mem_rdata;
    logic          mem_we;

    sort_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .a_gt_b (a_gt_b),
        .zi     (zi),
        .zj     (zj),
        .state  (state),
        .ctl    (ctl),
        .done   (done)
    );

    sort_path #(.W(W), .AW(AW)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .ext_addr  (addr),
        .ext_data  (wr_data),
        .ext_we    (wr_en),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .a_gt_b    (a_gt_b),
        .zi        (zi),
        .zj        (zj)
    );

    sort_store #(.W(W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign rd_data = (rd_en && ctl.ext_sel) ? mem_rdata : '0;

    // R10: after compare or reload, A never exceeds B
    a_r10_min_held : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NEXT) |-> !a_gt_b);

    // R8: no write reaches memory while sorting except swap cycles
    a_r8_busy_no_ext : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state != S_IDLE) |-> (state == S_WR_I || state == S_WR_J));

endmodule

// File: tb/sort_engine_tb.sv
module sort_engine_tb_top;
    localparam int W  = 8;
    localparam int AW = 2;
    localparam int K  = 1 << AW;
    localparam int BASE_LAT = 1 + (K - 1) + 3 * K * (K - 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          done;

    int checks = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;

    sort_engine #(.W(W), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .done(done)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick(int c);
        case (c & 3)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h80;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic write_word(int a, logic [W-1:0] d);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(int a, output logic [W-1:0] d);
        addr = AW'(a); rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    logic [W-1:0] src [K];
    logic [W-1:0] ref_m [K];
    logic [W-1:0] got;

    initial begin
        int swaps, n;
        logic [W-1:0] t;
        @(negedge clk);
        // R1: reset state
        check("R1 done in reset", int'(done), 0);
        rd_en = 1'b0;
        #1 check("R3 rd_data with rd_en low", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 plain load and readback, then reset keeps memory (R1)
        for (int a = 0; a < K; a++) write_word(a, W'(8'h30 + a));
        for (int a = 0; a < K; a++) begin
            read_word(a, got);
            check("R2 load readback", int'(got), 8'h30 + a);
        end
        addr = '0; #1 check("R3 rd_en low gives zero", int'(rd_data), 0);
        rst_n = 1'b0; #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after mid reset", int'(done), 0);
        for (int a = 0; a < K; a++) begin
            read_word(a, got);
            check("R1 memory kept over reset", int'(got), 8'h30 + a);
        end

        for (int p = 0; p < 256; p++) begin
            for (int a = 0; a < K; a++) begin
                src[a] = pick(p >> (2 * a));
                ref_m[a] = src[a];
                write_word(a, src[a]);
            end
            // reference exchange sort, strict unsigned compare (R5)
            swaps = 0;
            for (int i = 0; i < K - 1; i++)
                for (int j = i + 1; j < K; j++)
                    if (ref_m[i] > ref_m[j]) begin
                        t = ref_m[i]; ref_m[i] = ref_m[j]; ref_m[j] = t;
                        swaps++;
                    end

            run = 1'b1;
            n = 0;
            while (1) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                wr_en = 1'b0;
                if (done || n > 200) break;
                if (n == 4) begin
                    // R8: stray write while sorting; R3: read while busy
                    addr = AW'(p); wr_data = 8'h5A; wr_en = 1'b1;
                    rd_en = 1'b1;
                    #1 if (p < 8) check("R3 rd_data zero while busy", int'(rd_data), 0);
                    rd_en = 1'b0;
                end
            end
            check("R6 latency", n, BASE_LAT + 3 * swaps);

            @(posedge clk); @(negedge clk);
            check("R7 done held with run high", int'(done), 1);
            for (int a = 0; a < K; a++) begin
                read_word(a, got);
                // R4, R5, R8 sorted permutation; R9/R10 bounds and min upheld
                check("R4 sorted slot", int'(got), int'(ref_m[a]));
            end
            run = 1'b0;
            @(posedge clk); @(negedge clk);
            check("R7 done clears after run low", int'(done), 0);
        end
        summary();
    end
endmodule